// File: doc/BRIEF.md
# Three-Channel Interleaved Timer Register Front-End

This block puts three identical 16-bit timer channels behind one simple 32-bit register bus (address, write strobe, write data, read strobe, read data). Registers of one kind for the three channels sit in adjacent words. The front-end therefore splits every word index into a register kind and a channel number. It trims write data to each register's width and sends the write to the addressed channel. It returns registered read data and clears a channel's interrupt flags when that channel's status word is read.

Each channel counts up or down on a tick. The tick can be divided down by a power-of-two prescaler. A channel either wraps at a programmed interval or runs the full 16-bit range. It raises flags on wrap, on interval reload and on equality with three compare values. Each channel drives its own interrupt line, which is high while any flag that is enabled is set.

Top module: `tri_timer_regs`

## Requirements
- R1: The word index is byte address bits [7:2]. The register kind is word/3 and the channel is word%3. Kinds in word order: clock config (0x00), control (0x0C), count (0x18), interval (0x24), compare 1 (0x30), compare 2 (0x3C), compare 3 (0x48), status (0x54), interrupt enable (0x60), event config (0x6C), event value (0x78). Channel c adds 4*c.
- R2: After reset the control register reads 0x21, every other register reads 0, and all interrupt lines are low.
- R3: Written values keep bits [5:0] for clock config and interrupt enable, [15:0] for interval and compare, and [2:0] for event config. Control keeps bits [5:0] with bit 4 forced to 0.
- R4: Writes to count, status and event value are ignored. Event value reads 0. Count reads as the 16-bit value, zero-extended.
- R5: An access with address bits [1:0] not zero, or with a word index above 32, reads 0, writes nothing and clears nothing.
- R6: Read data is registered and appears in the cycle after the read strobe. It holds its value while no read is made.
- R7: A status read returns the flags and clears them for that channel only. A flag raised in the same cycle survives.
- R8: Control bits: bit 0 stops counting, bit 1 selects interval mode, bit 2 counts down, bit 3 enables compares. Writing 1 to bit 4 zeroes the count.
- R9: Counting up in interval mode, a tick at count == interval loads 0 and sets status bit 0. Outside interval mode, a tick at 0xFFFF loads 0 and sets status bit 4.
- R10: Counting down, a tick at 0 loads the interval and sets bit 0 in interval mode. Otherwise it loads 0xFFFF and sets bit 4.
- R11: With compares enabled, a tick that makes the count equal to compare k (k = 1..3) sets status bit k.
- R12: Clock config bit 0 enables the prescaler. Bits [4:1] = N then allow one tick every 2^(N+1) cycles. With the prescaler off, every cycle is a tick.
- R13: A channel's interrupt line is the OR of its status bits ANDed with its enable bits.
- R14: A write to one compare register changes that compare register alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 3 | Per-channel interrupt lines |

## Verification
Counter state is only visible over the bus, so the value a channel reaches depends on exact cycle counts between two control writes. The stimulus starts a channel with one write and stops it with another after a chosen idle gap. This gives a known number of ticks, including the prescaled cases where the first tick arrives late. Each wrap, reload and compare event is reached this way from a known count. The flags of two channels are then raised before one status word is read, which shows that clear-on-read leaves the other channel untouched.

// File: rtl/ttr_pkg.sv
package ttr_pkg;

   typedef enum logic [3:0] {
      RK_CLKCFG = 4'd0,
      RK_CTRL   = 4'd1,
      RK_COUNT  = 4'd2,
      RK_INTV   = 4'd3,
      RK_MATCH0 = 4'd4,
      RK_MATCH1 = 4'd5,
      RK_MATCH2 = 4'd6,
      RK_STAT   = 4'd7,
      RK_IEN    = 4'd8,
      RK_EVCFG  = 4'd9,
      RK_EVVAL  = 4'd10
   } reg_kind_e;

   localparam int N_KINDS  = 11;
   localparam int N_MATCH  = 3;

   localparam int CLKCFG_W = 6;
   localparam int CTRL_W   = 6;
   localparam int STAT_W   = 6;
   localparam int IEN_W    = 6;
   localparam int EVCFG_W  = 3;

   // control register bit positions
   localparam int CB_STOP  = 0;
   localparam int CB_INTV  = 1;
   localparam int CB_DOWN  = 2;
   localparam int CB_MATCH = 3;
   localparam int CB_ZERO  = 4;

   localparam logic [CTRL_W-1:0] CTRL_RST  = 6'h21;
   localparam logic [CTRL_W-1:0] CTRL_KEEP = 6'h2F;

   // status bit positions
   localparam int SB_INTV   = 0;
   localparam int SB_MATCH0 = 1;
   localparam int SB_WRAP   = 4;

   // clock config fields
   localparam int PS_EN_BIT  = 0;
   localparam int PS_SEL_LSB = 1;
   localparam int PS_SEL_W   = 4;

endpackage

// File: rtl/ttr_decode.sv
module ttr_decode
   import ttr_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int N_CH   = 3,
   localparam int CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output reg_kind_e         kind,
   output logic [CH_W-1:0]   ch
);

   localparam int WORD_W  = ADDR_W - 2;
   localparam int N_WORDS = N_KINDS * N_CH;

   logic [WORD_W-1:0] word;
   logic [31:0]       grp_w;
   logic [31:0]       chn_w;
   logic              unused_dec;

   assign word = addr[ADDR_W-1:2];

   always_comb begin
      hit   = (addr[1:0] == 2'b00) && (32'(word) < 32'(N_WORDS));
      grp_w = 32'(word) / 32'(N_CH);
      chn_w = 32'(word) % 32'(N_CH);
      kind  = hit ? reg_kind_e'(grp_w[3:0]) : RK_CLKCFG;
      ch    = hit ? chn_w[CH_W-1:0] : '0;
   end

   assign unused_dec = ^{grp_w[31:4], chn_w[31:CH_W]};

endmodule

// File: rtl/ttr_prescale.sv
module ttr_prescale #(
   parameter int SEL_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             en,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);

   localparam int PRE_W = 2 ** SEL_W;

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] limit;
   logic [PRE_W:0]   span;

   always_comb begin
      span  = {{PRE_W{1'b0}}, 1'b1} << ({1'b0, sel} + 1'b1);
      limit = span[PRE_W-1:0] - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pre_q <= '0;
      else if (!run || !en)      pre_q <= '0;
      else if (pre_q == limit)   pre_q <= '0;
      else                       pre_q <= pre_q + 1'b1;
   end

   assign tick = run && (!en || (pre_q == limit));

endmodule

// File: rtl/ttr_channel.sv
module ttr_channel
   import ttr_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int CNT_W        = 16,
   parameter bit HAS_PRESCALE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_sel,
   input  logic              clr,
   input  reg_kind_e         kind,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rd_word,
   output logic              irq
);

   logic [CLKCFG_W-1:0] clkcfg_q;
   logic [CTRL_W-1:0]   ctrl_q;
   logic [CNT_W-1:0]    count_q, count_d;
   logic [CNT_W-1:0]    intv_q;
   logic [CNT_W-1:0]    match_q [N_MATCH];
   logic [STAT_W-1:0]   stat_q, stat_set;
   logic [IEN_W-1:0]    ien_q;
   logic [EVCFG_W-1:0]  evcfg_q;
   logic                run, tick, wr_zero;
   logic                unused_wd;

   assign run       = !ctrl_q[CB_STOP];
   assign wr_zero   = wr_sel && (kind == RK_CTRL) && wdata[CB_ZERO];
   assign unused_wd = ^wdata[DATA_W-1:CNT_W];

   // tick source: divided or direct
   generate
      if (HAS_PRESCALE) begin : g_pre
         ttr_prescale #(.SEL_W(PS_SEL_W)) u_pre (
            .clk  (clk),
            .rst_n(rst_n),
            .run  (run),
            .en   (clkcfg_q[PS_EN_BIT]),
            .sel  (clkcfg_q[PS_SEL_LSB +: PS_SEL_W]),
            .tick (tick)
         );
      end else begin : g_direct
         assign tick = run;
      end
   endgenerate

   // next count and event flags
   always_comb begin
      count_d  = count_q;
      stat_set = '0;
      if (tick) begin
         if (!ctrl_q[CB_DOWN]) begin
            if (ctrl_q[CB_INTV] && (count_q == intv_q)) begin
               count_d           = '0;
               stat_set[SB_INTV] = 1'b1;
            end else if (&count_q) begin
               count_d           = '0;
               stat_set[SB_WRAP] = 1'b1;
            end else begin
               count_d = count_q + 1'b1;
            end
         end else begin
            if (count_q == '0) begin
               if (ctrl_q[CB_INTV]) begin
                  count_d           = intv_q;
                  stat_set[SB_INTV] = 1'b1;
               end else begin
                  count_d           = '1;
                  stat_set[SB_WRAP] = 1'b1;
               end
            end else begin
               count_d = count_q - 1'b1;
            end
         end
         if (ctrl_q[CB_MATCH]) begin
            for (int m = 0; m < N_MATCH; m++) begin
               if (count_d == match_q[m]) stat_set[SB_MATCH0 + m] = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clkcfg_q <= '0;
         ctrl_q   <= CTRL_RST;
         count_q  <= '0;
         intv_q   <= '0;
         stat_q   <= '0;
         ien_q    <= '0;
         evcfg_q  <= '0;
      end else begin
         count_q <= wr_zero ? '0 : count_d;
         stat_q  <= (clr ? '0 : stat_q) | stat_set;
         if (wr_sel) begin
            case (kind)
               RK_CLKCFG: clkcfg_q <= wdata[CLKCFG_W-1:0];
               RK_CTRL:   ctrl_q   <= wdata[CTRL_W-1:0] & CTRL_KEEP;
               RK_INTV:   intv_q   <= wdata[CNT_W-1:0];
               RK_IEN:    ien_q    <= wdata[IEN_W-1:0];
               RK_EVCFG:  evcfg_q  <= wdata[EVCFG_W-1:0];
               default:   ;
            endcase
         end
      end
   end

   // one register per compare slot
   generate
      for (genvar m = 0; m < N_MATCH; m++) begin : g_match
         logic hit_m;
         assign hit_m = wr_sel && (4'(kind) == (4'(RK_MATCH0) + 4'(m)));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     match_q[m] <= '0;
            else if (hit_m) match_q[m] <= wdata[CNT_W-1:0];
         end
      end
   endgenerate

   always_comb begin
      case (kind)
         RK_CLKCFG: rd_word = DATA_W'(clkcfg_q);
         RK_CTRL:   rd_word = DATA_W'(ctrl_q);
         RK_COUNT:  rd_word = DATA_W'(count_q);
         RK_INTV:   rd_word = DATA_W'(intv_q);
         RK_MATCH0: rd_word = DATA_W'(match_q[0]);
         RK_MATCH1: rd_word = DATA_W'(match_q[1]);
         RK_MATCH2: rd_word = DATA_W'(match_q[2]);
         RK_STAT:   rd_word = DATA_W'(stat_q);
         RK_IEN:    rd_word = DATA_W'(ien_q);
         RK_EVCFG:  rd_word = DATA_W'(evcfg_q);
         default:   rd_word = '0;
      endcase
   end

   assign irq = |(stat_q & ien_q);

endmodule

// File: rtl/tri_timer_regs.sv
module tri_timer_regs
   import ttr_pkg::*;
#(
   parameter int ADDR_W       = 8,
   parameter int DATA_W       = 32,
   parameter int N_CH         = 3,
   parameter int CNT_W        = 16,
   parameter bit HAS_PRESCALE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [N_CH-1:0]   irq
);

   localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1;

   // elaboration-time parameter checks
   generate
      if (N_CH < 1) begin : g_bad_nch
         $error("tri_timer_regs: N_CH must be at least 1");
      end
      if ((2 ** (ADDR_W - 2)) < (N_KINDS * N_CH)) begin : g_bad_addr
         $error("tri_timer_regs: ADDR_W too narrow for register map");
      end
      if ((DATA_W <= CNT_W) || (CNT_W < 8)) begin : g_bad_width
         $error("tri_timer_regs: need 8 <= CNT_W < DATA_W");
      end
   endgenerate

   logic              dec_hit;
   reg_kind_e         dec_kind;
   logic [CH_W-1:0]   dec_ch;
   logic [N_CH-1:0]   wr_vec;
   logic [N_CH-1:0]   clr_vec;
   logic [DATA_W-1:0] ch_rd [N_CH];
   logic [DATA_W-1:0] rd_mux;

   ttr_decode #(.ADDR_W(ADDR_W), .N_CH(N_CH)) u_dec (
      .addr(bus_addr),
      .hit (dec_hit),
      .kind(dec_kind),
      .ch  (dec_ch)
   );

   generate
      for (genvar c = 0; c < N_CH; c++) begin : g_ch
         assign wr_vec[c]  = bus_wr && dec_hit && (dec_ch == CH_W'(c));
         assign clr_vec[c] = bus_rd && dec_hit && (dec_kind == RK_STAT)
                             && (dec_ch == CH_W'(c));
         ttr_channel #(
            .DATA_W      (DATA_W),
            .CNT_W       (CNT_W),
            .HAS_PRESCALE(HAS_PRESCALE)
         ) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_sel (wr_vec[c]),
            .clr    (clr_vec[c]),
            .kind   (dec_kind),
            .wdata  (bus_wdata),
            .rd_word(ch_rd[c]),
            .irq    (irq[c])
         );
      end
   endgenerate

   always_comb begin
      rd_mux = '0;
      for (int c = 0; c < N_CH; c++) begin
         if (dec_hit && (dec_ch == CH_W'(c))) rd_mux = ch_rd[c];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end

endmodule

// File: rtl/ttr_checker.sv
module ttr_checker
   import ttr_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int N_CH   = 3,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_rd,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [N_CH-1:0]   clr_vec
);

   logic [ADDR_W-3:0] word;
   logic              aligned, in_count, beyond;

   assign word     = bus_addr[ADDR_W-1:2];
   assign aligned  = (bus_addr[1:0] == 2'b00);
   assign in_count = aligned && (32'(word) >= 32'(2 * N_CH)) && (32'(word) < 32'(3 * N_CH));
   assign beyond   = 32'(word) >= 32'(N_KINDS * N_CH);

   AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(clr_vec));                                             // R7
   AST_CLR_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (|clr_vec) |-> (bus_rd && aligned && !beyond));                 // R5
   AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));                                // R6
   AST_MISALIGN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !aligned) |=> (bus_rdata == '0));                    // R5
   AST_BEYOND_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && beyond) |=> (bus_rdata == '0));                      // R5
   AST_COUNT_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && in_count) |=> (bus_rdata[DATA_W-1:CNT_W] == '0));    // R4

endmodule

bind tri_timer_regs ttr_checker #(
   .ADDR_W(ADDR_W),
   .DATA_W(DATA_W),
   .N_CH  (N_CH),
   .CNT_W (CNT_W)
) u_ttr_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_addr (bus_addr),
   .bus_rd   (bus_rd),
   .bus_rdata(bus_rdata),
   .clr_vec  (clr_vec)
);

// File: tb/test_tri_timer_regs.sv
`timescale 1ns/1ps
module test_tri_timer_regs;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;
   logic [2:0]  irq;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic [31:0] exp_q [$];
   string       tag_q [$];
   logic        rd_pend = 1'b0;

   always #2.5 clk = ~clk;

   tri_timer_regs i_tri_timer_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_wr   (bus_wr),
      .bus_wdata(bus_wdata),
      .bus_rd   (bus_rd),
      .bus_rdata(bus_rdata),
      .irq      (irq)
   );

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string tag);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input logic [31:0] act, input logic [31:0] e, input string tag);
      n_checks++;
      if (act !== e) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, e);
      end
   endtask

   // monitor: compare registered read data against the scoreboard
   always @(posedge clk) rd_pend <= bus_rd;

   always @(negedge clk) begin
      if (rd_pend) begin
         logic [31:0] e;
         string       t;
         if (exp_q.size() == 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL R6: read data with empty scoreboard, actual %h expected none", bus_rdata);
         end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(bus_rdata, e, t);
         end
      end
   end

   initial begin
      #(20000 * 5.0);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R2: reset state
      check({29'd0, irq}, 32'd0, "R2 irq after reset");
      bus_read(8'h0C, 32'h21, "R2 ctrl ch0 reset");
      bus_read(8'h10, 32'h21, "R2 ctrl ch1 reset");
      bus_read(8'h14, 32'h21, "R2 ctrl ch2 reset");
      bus_read(8'h28, 32'h0,  "R2 interval ch1 reset");

      // R3: write masks
      bus_write(8'h08, 32'hFFFF_FFFF);
      bus_read(8'h08, 32'h3F, "R3 clock config mask");
      bus_write(8'h08, 32'h0);
      bus_write(8'h68, 32'hFFFF_FFFF);
      bus_read(8'h68, 32'h3F, "R3 irq enable mask");
      bus_write(8'h6C, 32'hFFFF_FFFF);
      bus_read(8'h6C, 32'h7, "R3 event config mask");
      bus_write(8'h24, 32'hABCD_1234);
      bus_read(8'h24, 32'h1234, "R3 interval mask");
      bus_write(8'h14, 32'hFFFF_FFFF);
      bus_read(8'h14, 32'h2F, "R3 R8 control mask drops zero bit");

      // R1: interleaved channel selection
      bus_write(8'h28, 32'h2222);
      bus_write(8'h2C, 32'h3333);
      bus_read(8'h24, 32'h1234, "R1 interval ch0");
      bus_read(8'h28, 32'h2222, "R1 interval ch1");
      bus_read(8'h2C, 32'h3333, "R1 interval ch2");

      // R14: compare registers independent
      bus_write(8'h30, 32'h0A0A);
      bus_write(8'h3C, 32'h0B0B);
      bus_read(8'h30, 32'h0A0A, "R14 compare1 ch0");
      bus_read(8'h3C, 32'h0B0B, "R14 compare2 ch0");
      bus_read(8'h48, 32'h0,    "R14 compare3 ch0 untouched");
      bus_read(8'h34, 32'h0,    "R14 compare1 ch1 untouched");

      // R5: undefined and misaligned
      bus_read(8'h84, 32'h0, "R5 word past map");
      bus_read(8'hFC, 32'h0, "R5 top word");
      bus_read(8'h26, 32'h0, "R5 misaligned read");
      bus_write(8'h25, 32'hFFFF);
      bus_write(8'h84, 32'hFFFF_FFFF);
      bus_read(8'h24, 32'h1234, "R5 misaligned write ignored");
      bus_read(8'h00, 32'h0,    "R5 undefined write ignored");

      // R4: read-only registers
      bus_write(8'h1C, 32'h55);
      bus_read(8'h1C, 32'h0, "R4 count write ignored");
      bus_write(8'h7C, 32'hFF);
      bus_read(8'h7C, 32'h0, "R4 event value reads zero");
      bus_write(8'h58, 32'h3F);
      bus_read(8'h58, 32'h0, "R4 status write ignored");

      // R9: up count in interval mode, 7 ticks with interval 4
      bus_write(8'h28, 32'h4);
      bus_write(8'h64, 32'h1);
      bus_write(8'h10, 32'h02);
      idle(5);
      bus_write(8'h10, 32'h03);
      check({29'd0, irq}, 32'b010, "R13 irq ch1 on interval flag");
      bus_read(8'h1C, 32'h2,  "R9 count after interval wrap");
      bus_read(8'h58, 32'h01, "R9 interval flag");
      check({29'd0, irq}, 32'b000, "R7 R13 irq drops after status read");
      bus_read(8'h58, 32'h0,  "R7 status cleared by read");

      // R11: compare 3 on ch2, 5 ticks up
      bus_write(8'h50, 32'h3);
      bus_write(8'h14, 32'h08);
      idle(3);
      bus_write(8'h14, 32'h09);
      check({29'd0, irq}, 32'b100, "R13 irq ch2 on compare flag");
      bus_read(8'h20, 32'h5, "R11 count ch2");

      // R10: down count without interval, 2 ticks from 0
      bus_write(8'h0C, 32'h04);
      bus_write(8'h0C, 32'h05);
      bus_read(8'h18, 32'hFFFE, "R10 down wrap count");

      // R7: clear only the channel read
      bus_read(8'h5C, 32'h08, "R11 compare3 flag");
      bus_read(8'h54, 32'h10, "R7 R10 ch0 flags survive ch2 read");
      bus_read(8'h5C, 32'h0,  "R7 ch2 cleared");

      // R10: down with interval reload, 4 ticks from 2
      bus_write(8'h10, 32'h06);
      idle(2);
      bus_write(8'h10, 32'h07);
      bus_read(8'h1C, 32'h3,  "R10 reload from interval");
      bus_read(8'h58, 32'h01, "R10 reload flag");

      // R8 R12: zeroing and prescaler /2
      bus_write(8'h10, 32'h13);
      bus_read(8'h10, 32'h03, "R8 zero bit not stored");
      bus_read(8'h1C, 32'h0,  "R8 count zeroed");
      bus_write(8'h04, 32'h01);
      bus_write(8'h10, 32'h00);
      idle(6);
      bus_write(8'h10, 32'h01);
      bus_read(8'h1C, 32'h4, "R12 divide by 2");

      // R12: prescaler /4
      bus_write(8'h04, 32'h03);
      bus_write(8'h10, 32'h11);
      bus_write(8'h10, 32'h00);
      idle(10);
      bus_write(8'h10, 32'h01);
      bus_read(8'h1C, 32'h3, "R12 divide by 4");

      idle(3);
      if (exp_q.size() != 0) begin
         n_checks++;
         n_fail++;
         $display("FAIL R6: actual %0d reads unanswered expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule